// File: doc/BRIEF.md
# Event-Triggered Peripheral-to-Buffer DMA Channel

This block is a single DMA channel that drains a peripheral data stream into a memory buffer. Each strobe on the sync event input, such as a receive-ready pulse from a serial port, moves exactly one data element. The element is read from a peripheral data register whose address is programmed as the source and normally stays fixed. It is then written to a buffer location that advances by a programmed index after every element. A separate instance of the channel serves each direction of a stream, so a transmit stream and a receive stream can use different counts and element sizes.

Software programs the channel through a simple write-only register port. The registers hold the source and destination addresses, a signed index for each side, the element count, and a control word. The control word carries the event-enable bit, the element size and the queue tag. Writing a nonzero count arms the channel. Each element is carried out as one single-beat read followed by one single-beat write on the memory master port. The queue tag is presented alongside every request so that a downstream arbiter can favour latency-critical streams; queue 0 is the most urgent. When the last element has been written, the channel disarms and raises a one-cycle completion pulse.

Top module: `evdma_channel`

## Requirements
- R1: While control bit 0 (event enable) is 0, sync events start no transfer and are not remembered. After enable is set again, only later events start transfers.
- R2: An accepted event on an armed, idle channel puts a read request (mem_we_o=0) at the source address on the port in the next cycle. When the read data returns, exactly one write request (mem_we_o=1) follows in the next cycle, and no further request is made for that event.
- R3: After each element's write is granted, the source address becomes source address plus source index (two's complement). An index of 0 keeps the source address fixed.
- R4: After each element's write is granted, the destination address becomes destination address plus destination index (two's complement), starting from the programmed buffer address. Negative indexes step downward.
- R5: Control bits [2:1] select the element size: 0 is 1 byte, 1 is 2 bytes, and 2 or 3 is 4 bytes. Byte enables are the size mask shifted left by the low address bits of the accessed side. The element is taken from the read data lanes at the source offset and placed in the write data lanes at the destination offset.
- R6: Register 4 (count) arms the channel when written nonzero and decrements on each granted write. When it reaches zero, done_o is high for exactly the one cycle after that write grant, and later events are ignored until the count is written again.
- R7: An enabled event that arrives while an element is in flight is held pending. The pending element starts in the cycle after the channel returns to idle, with no new event.
- R8: An enabled event that arrives while an element is in flight and one event is already pending sets miss_err_o. The flag stays set until register 4 is written.
- R9: mem_qid_o equals control bits [8 +: QID_W], the queue tag.
- R10: While mem_req_o is high and mem_gnt_i is low, the request, its direction and its address stay unchanged in the following cycle.

Register select codes on cfg_sel_i: 0 source address, 1 destination address, 2 source index, 3 destination index, 4 count, 5 control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_sel_i | input | 3 | Register select |
| cfg_wdata_i | input | ADDR_W | Register write data |
| sync_ev_i | input | 1 | Peripheral sync event, one element per cycle high |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Request byte address |
| mem_be_o | output | DATA_W/8 | Byte enables |
| mem_wdata_o | output | DATA_W | Write data |
| mem_qid_o | output | QID_W | Queue tag for the request |
| mem_gnt_i | input | 1 | Request accepted this cycle |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | DATA_W | Read data |
| done_o | output | 1 | One-cycle completion pulse |
| miss_err_o | output | 1 | Sticky event-missed flag |

## Verification
An event sampled at one clock edge shows up as a read request just after that edge. The write request follows one cycle after the edge that samples read valid. The address, count and completion effects of a write appear one cycle after the edge that grants it, and the missed-event flag rises at the edge that samples the offending event. The bench updates a behavioural model at every rising edge from the inputs it drove at the preceding falling edge. It compares every output with that model at the next falling edge, so each result is checked in the very cycle it becomes due and in no other. Stalls on the grant, ignored events and back-to-back events are all timed through that same per-cycle comparison.

// File: rtl/evdma_pkg.sv
package evdma_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_RD    = 2'd1,
      ST_RWAIT = 2'd2,
      ST_WR    = 2'd3
   } xfer_state_e;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_SIDX = 3'd2;
   localparam logic [2:0] SEL_DIDX = 3'd3;
   localparam logic [2:0] SEL_CNT  = 3'd4;
   localparam logic [2:0] SEL_CTRL = 3'd5;

   localparam int CTRL_EN_BIT = 0;
   localparam int CTRL_SZ_LSB = 1;
   localparam int CTRL_Q_LSB  = 8;

   function automatic logic [2:0] elem_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         default: return 3'd4;
      endcase
   endfunction

endpackage

// File: rtl/evdma_addr.sv
module evdma_addr #(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              base_we,
   input  logic              idx_we,
   input  logic [ADDR_W-1:0] wdata,
   input  logic              step,
   output logic [ADDR_W-1:0] addr
);

   logic [ADDR_W-1:0] idx_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr  <= '0;
         idx_q <= '0;
      end else begin
         if (idx_we) idx_q <= wdata;
         if (base_we)   addr <= wdata;
         else if (step) addr <= addr + idx_q;
      end
   end

endmodule

// File: rtl/evdma_lane.sv
module evdma_lane
   import evdma_pkg::*;
#(
   parameter  int DATA_W = 32,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic [1:0]        size_code,
   input  logic [OFF_W-1:0]  src_off,
   input  logic [OFF_W-1:0]  dst_off,
   input  logic [DATA_W-1:0] cap_data,
   output logic [LANES-1:0]  rd_be,
   output logic [LANES-1:0]  wr_be,
   output logic [DATA_W-1:0] wr_data
);

   logic [2:0]        nbytes;
   logic [LANES-1:0]  keep;
   logic [DATA_W-1:0] keep_bits;
   logic [DATA_W-1:0] aligned;

   assign nbytes = elem_bytes(size_code);

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign keep[l]             = (l < int'(nbytes));
      assign keep_bits[8*l +: 8] = {8{keep[l]}};
   end

   assign aligned = (cap_data >> {src_off, 3'b000}) & keep_bits;
   assign rd_be   = keep << src_off;
   assign wr_be   = keep << dst_off;
   assign wr_data = aligned << {dst_off, 3'b000};

endmodule

// File: rtl/evdma_seq.sv
module evdma_seq
   import evdma_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ev_i,
   input  logic             en_i,
   input  logic             cnt_we,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             gnt_i,
   input  logic             rvalid_i,
   output logic             rd_req_o,
   output logic             wr_req_o,
   output logic             cap_o,
   output logic             step_o,
   output logic             done_o,
   output logic             miss_o
);

   xfer_state_e      st_q, st_d;
   logic [CNT_W-1:0] cnt_q;
   logic             active_q, pend_q, miss_q, done_q;
   logic             ev_ok, busy, start, last;

   assign ev_ok    = ev_i & en_i & active_q;
   assign busy     = (st_q != ST_IDLE);
   assign start    = !busy & active_q & (ev_ok | pend_q);
   assign step_o   = (st_q == ST_WR) & gnt_i;
   assign last     = step_o & (cnt_q == CNT_W'(1));
   assign rd_req_o = (st_q == ST_RD);
   assign wr_req_o = (st_q == ST_WR);
   assign cap_o    = (st_q == ST_RWAIT) & rvalid_i;
   assign done_o   = done_q;
   assign miss_o   = miss_q;

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (start)    st_d = ST_RD;
         ST_RD:    if (gnt_i)    st_d = ST_RWAIT;
         ST_RWAIT: if (rvalid_i) st_d = ST_WR;
         ST_WR:    if (gnt_i)    st_d = ST_IDLE;
         default:                st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_IDLE;
         cnt_q    <= '0;
         active_q <= 1'b0;
         pend_q   <= 1'b0;
         miss_q   <= 1'b0;
         done_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         done_q <= last;
         if (cnt_we)      cnt_q <= cnt_wdata;
         else if (step_o) cnt_q <= cnt_q - CNT_W'(1);
         if (cnt_we)    active_q <= (cnt_wdata != '0);
         else if (last) active_q <= 1'b0;
         if (cnt_we)              pend_q <= 1'b0;
         else if (last)           pend_q <= 1'b0;
         else if (start)          pend_q <= 1'b0;
         else if (busy && ev_ok)  pend_q <= 1'b1;
         if (cnt_we)                         miss_q <= 1'b0;
         else if (busy && ev_ok && pend_q)   miss_q <= 1'b1;
      end
   end

   // R6
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q);

   // R8
   miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_q && !cnt_we) |=> miss_q);

   // R7
   pend_serve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !busy && active_q && !cnt_we) |=> (st_q == ST_RD));

   // R1
   idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_q && !busy) |=> !busy);

endmodule

// File: rtl/evdma_channel.sv
module evdma_channel
   import evdma_pkg::*;
#(
   parameter  int ADDR_W = 32,
   parameter  int DATA_W = 32,
   parameter  int CNT_W  = 16,
   parameter  int QID_W  = 2,
   localparam int LANES  = DATA_W / 8,
   localparam int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we_i,
   input  logic [2:0]        cfg_sel_i,
   input  logic [ADDR_W-1:0] cfg_wdata_i,
   input  logic              sync_ev_i,
   output logic              mem_req_o,
   output logic              mem_we_o,
   output logic [ADDR_W-1:0] mem_addr_o,
   output logic [LANES-1:0]  mem_be_o,
   output logic [DATA_W-1:0] mem_wdata_o,
   output logic [QID_W-1:0]  mem_qid_o,
   input  logic              mem_gnt_i,
   input  logic              mem_rvalid_i,
   input  logic [DATA_W-1:0] mem_rdata_i,
   output logic              done_o,
   output logic              miss_err_o
);

   if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data_w
      $error("evdma_channel: DATA_W must be a power of two of at least 32");
   end
   if (ADDR_W < CNT_W || ADDR_W < CTRL_Q_LSB + QID_W) begin : g_bad_addr_w
      $error("evdma_channel: ADDR_W too narrow for count or control fields");
   end

   logic              en_q;
   logic [1:0]        size_q;
   logic [QID_W-1:0]  qid_q;
   logic [DATA_W-1:0] cap_q;
   logic [ADDR_W-1:0] src_addr, dst_addr;
   logic [LANES-1:0]  rd_be, wr_be;
   logic [DATA_W-1:0] wr_data;
   logic              rd_req, wr_req, cap, step;
   logic              we_src, we_dst, we_sidx, we_didx, we_cnt, we_ctrl;

   assign we_src  = cfg_we_i && (cfg_sel_i == SEL_SRC);
   assign we_dst  = cfg_we_i && (cfg_sel_i == SEL_DST);
   assign we_sidx = cfg_we_i && (cfg_sel_i == SEL_SIDX);
   assign we_didx = cfg_we_i && (cfg_sel_i == SEL_DIDX);
   assign we_cnt  = cfg_we_i && (cfg_sel_i == SEL_CNT);
   assign we_ctrl = cfg_we_i && (cfg_sel_i == SEL_CTRL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         size_q <= 2'd0;
         qid_q  <= '0;
         cap_q  <= '0;
      end else begin
         if (we_ctrl) begin
            en_q   <= cfg_wdata_i[CTRL_EN_BIT];
            size_q <= cfg_wdata_i[CTRL_SZ_LSB +: 2];
            qid_q  <= cfg_wdata_i[CTRL_Q_LSB +: QID_W];
         end
         if (cap) cap_q <= mem_rdata_i;
      end
   end

   evdma_addr #(.ADDR_W(ADDR_W)) u_src (
      .clk(clk), .rst_n(rst_n), .base_we(we_src), .idx_we(we_sidx),
      .wdata(cfg_wdata_i), .step(step), .addr(src_addr)
   );

   evdma_addr #(.ADDR_W(ADDR_W)) u_dst (
      .clk(clk), .rst_n(rst_n), .base_we(we_dst), .idx_we(we_didx),
      .wdata(cfg_wdata_i), .step(step), .addr(dst_addr)
   );

   evdma_lane #(.DATA_W(DATA_W)) u_lane (
      .size_code(size_q),
      .src_off(src_addr[OFF_W-1:0]),
      .dst_off(dst_addr[OFF_W-1:0]),
      .cap_data(cap_q),
      .rd_be(rd_be),
      .wr_be(wr_be),
      .wr_data(wr_data)
   );

   evdma_seq #(.CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .ev_i(sync_ev_i), .en_i(en_q),
      .cnt_we(we_cnt), .cnt_wdata(cfg_wdata_i[CNT_W-1:0]),
      .gnt_i(mem_gnt_i), .rvalid_i(mem_rvalid_i),
      .rd_req_o(rd_req), .wr_req_o(wr_req), .cap_o(cap), .step_o(step),
      .done_o(done_o), .miss_o(miss_err_o)
   );

   assign mem_req_o   = rd_req | wr_req;
   assign mem_we_o    = wr_req;
   assign mem_addr_o  = rd_req ? src_addr : dst_addr;
   assign mem_be_o    = rd_req ? rd_be : wr_be;
   assign mem_wdata_o = wr_data;
   assign mem_qid_o   = qid_q;

   // R10
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && !mem_gnt_i && !cfg_we_i) |=>
         (mem_req_o && $stable(mem_we_o) && $stable(mem_addr_o)));

endmodule

// File: tb/evdma_channel_bench.sv
module evdma_channel_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [2:0]  cfg_sel = 3'd0;
   logic [31:0] cfg_wd = 32'd0;
   logic        sync_ev = 1'b0;
   logic        stall = 1'b0;
   logic        rv = 1'b0;
   logic [31:0] rdat = 32'd0;
   logic        mem_req, mem_we, done, miss;
   logic [31:0] mem_addr, mem_wdata;
   logic [3:0]  mem_be;
   logic [1:0]  mem_qid;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   evdma_channel u_evdma_channel (
      .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel),
      .cfg_wdata_i(cfg_wd), .sync_ev_i(sync_ev),
      .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
      .mem_be_o(mem_be), .mem_wdata_o(mem_wdata), .mem_qid_o(mem_qid),
      .mem_gnt_i(!stall), .mem_rvalid_i(rv), .mem_rdata_i(rdat),
      .done_o(done), .miss_err_o(miss)
   );

   // Behavioural reference model
   int          mph = 0;
   bit          mact = 0, mpend = 0, mmiss = 0, mdone = 0, men = 0;
   bit          m_evok, m_busy;
   int          mcnt = 0;
   logic [31:0] msrc = 0, mdst = 0, msidx = 0, mdidx = 0, mcap = 0;
   logic [31:0] pdata = 32'hA1B2C3D4;
   logic [1:0]  msize = 0, mq = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         mph = 0; mact = 0; mpend = 0; mmiss = 0; mdone = 0; men = 0;
         mcnt = 0; msrc = 0; mdst = 0; msidx = 0; mdidx = 0; mcap = 0;
         msize = 0; mq = 0;
      end else begin
         m_evok = sync_ev && men && mact;
         m_busy = (mph != 0);
         mdone = 0;
         if (m_busy && m_evok) begin
            if (mpend) mmiss = 1; else mpend = 1;
         end
         case (mph)
            0: if (mact && (m_evok || mpend)) begin mph = 1; mpend = 0; end
            1: if (!stall) mph = 2;
            2: if (rv) begin mcap = rdat; mph = 3; end
            default: if (!stall) begin
               msrc = msrc + msidx;
               mdst = mdst + mdidx;
               mcnt = mcnt - 1;
               pdata = pdata + 32'h1357_9BDF;
               mph = 0;
               if (mcnt == 0) begin mact = 0; mdone = 1; mpend = 0; end
            end
         endcase
         if (cfg_we) begin
            case (cfg_sel)
               3'd0: msrc = cfg_wd;
               3'd1: mdst = cfg_wd;
               3'd2: msidx = cfg_wd;
               3'd3: mdidx = cfg_wd;
               3'd4: begin
                  mcnt = int'(cfg_wd[15:0]);
                  mact = (cfg_wd[15:0] != 0);
                  mpend = 0; mmiss = 0;
               end
               3'd5: begin men = cfg_wd[0]; msize = cfg_wd[2:1]; mq = cfg_wd[9:8]; end
               default: ;
            endcase
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   int          nb;
   logic [3:0]  keepm;
   logic [31:0] bmask, exp_wd;
   bit          exp_req;

   always @(negedge clk) begin
      rv   <= (mph == 2);
      rdat <= pdata;
      if (!finished) begin
         nb = (msize == 0) ? 1 : (msize == 1) ? 2 : 4;
         keepm = 4'((1 << nb) - 1);
         bmask = (nb == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*nb)) - 1);
         exp_req = (mph == 1) || (mph == 3);
         chk("R1 R2 R6 R7 mem_req", {31'd0, mem_req}, {31'd0, exp_req});
         if (exp_req && mem_req) begin
            chk(stall ? "R10 mem_we" : "R2 mem_we", {31'd0, mem_we}, {31'd0, mph == 3});
            if (mph == 1) begin
               chk(stall ? "R10 R3 mem_addr(read)" : "R3 mem_addr(read)", mem_addr, msrc);
               chk("R5 mem_be(read)", {28'd0, mem_be}, {28'd0, keepm << msrc[1:0]});
            end else begin
               chk(stall ? "R10 R4 mem_addr(write)" : "R4 mem_addr(write)", mem_addr, mdst);
               chk("R5 mem_be(write)", {28'd0, mem_be}, {28'd0, keepm << mdst[1:0]});
               exp_wd = ((mcap >> (8*msrc[1:0])) & bmask) << (8*mdst[1:0]);
               chk("R5 mem_wdata", mem_wdata, exp_wd);
            end
         end
         chk("R6 done", {31'd0, done}, {31'd0, mdone});
         chk("R8 miss_err", {31'd0, miss}, {31'd0, mmiss});
         chk("R9 qid", {30'd0, mem_qid}, {30'd0, mq});
      end
   end

   task automatic wr(input logic [2:0] sel, input logic [31:0] val);
      @(negedge clk); cfg_we = 1'b1; cfg_sel = sel; cfg_wd = val;
      @(negedge clk); cfg_we = 1'b0;
   endtask

   task automatic pulse(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); sync_ev = 1'b1;
      end
      @(negedge clk); sync_ev = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   endtask

   initial begin
      idle(4);
      @(negedge clk); rst_n = 1'b1;
      idle(2);
      // R2 R3 R4: 4-byte words, fixed source, incrementing buffer, queue 0
      wr(3'd5, 32'h0000_0005);
      wr(3'd0, 32'h4000_0010);
      wr(3'd2, 32'd0);
      wr(3'd1, 32'h8000_0000);
      wr(3'd3, 32'd4);
      wr(3'd4, 32'd3);
      pulse(1); idle(6);
      // R10: stall both the read and the write request
      @(negedge clk); sync_ev = 1'b1; stall = 1'b1;
      @(negedge clk); sync_ev = 1'b0;
      idle(3); stall = 1'b0;
      @(negedge clk); stall = 1'b1;
      idle(3); stall = 1'b0;
      idle(5);
      pulse(1); idle(8);
      // R6: event after completion is ignored
      pulse(1); idle(5);
      // R1: disabled events are neither served nor remembered
      wr(3'd5, 32'h0000_0004);
      wr(3'd4, 32'd2);
      pulse(1); idle(2); pulse(1); idle(4);
      wr(3'd5, 32'h0000_0005);
      idle(4);
      pulse(1); idle(6); pulse(1); idle(8);
      // R5 R9: halfwords at offset 2, queue 2
      wr(3'd5, 32'h0000_0203);
      wr(3'd0, 32'h4000_0012);
      wr(3'd1, 32'h8000_0102);
      wr(3'd3, 32'd2);
      wr(3'd4, 32'd2);
      pulse(1); idle(6); pulse(1); idle(8);
      // R5 R4: bytes, unaligned source, descending buffer, queue 3
      wr(3'd5, 32'h0000_0301);
      wr(3'd0, 32'h4000_0011);
      wr(3'd1, 32'h8000_0203);
      wr(3'd3, 32'hFFFF_FFFF);
      wr(3'd4, 32'd3);
      pulse(1); idle(6); pulse(1); idle(6); pulse(1); idle(8);
      // R7 R8: three back-to-back events -> one pending, one missed
      wr(3'd5, 32'h0000_0005);
      wr(3'd1, 32'h8000_1000);
      wr(3'd3, 32'd4);
      wr(3'd4, 32'd4);
      pulse(3); idle(12);
      pulse(1); idle(6); pulse(1); idle(8);
      // R8: count rewrite clears the flag
      wr(3'd4, 32'd1);
      pulse(1); idle(8);
      // R3 R7: advancing source, two back-to-back events, no miss
      wr(3'd0, 32'h4000_0100);
      wr(3'd2, 32'd4);
      wr(3'd4, 32'd2);
      pulse(2); idle(14);
      summary();
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         summary();
      end
   end

endmodule